// File: doc/BRIEF.md
# SPI Slave Register Bridge

This block gives an external processor read and write access to a bank of 32-bit internal registers through a plain SPI slave port. The master opens a frame by pulling the bridge's chip select low. It shifts in a direction bit, then a word address, then, for a write, the data word. The bridge turns each complete frame into one access on a simple internal register bus. That bus answers with a one-cycle acknowledge after any number of cycles.

Registers behind the bus can be slow to answer. The bridge therefore starts a read as soon as the final address bit arrives. It then sends a programmable number of all-ones padding bytes before the first data bit, and the master clocks through them while the access completes. When padding is zero, the master must run the serial clock slowly enough that half a serial period covers the register latency. If the answer is still missing when the data must start, the bridge sends all ones and raises a sticky error flag.

The SPI pins are sampled by the system clock through synchronizers, so each serial clock phase must last at least `SYNC_STAGES + 3` system cycles. Only the first chip select line addresses this bridge. The other chip select lines may be wired to the same port and have no effect on it.

Top module: `spi_reg_bridge`

## Requirements
- R1: A frame uses SPI mode 0 (MOSI sampled on the rising serial clock edge, MISO changed on the falling edge), sent most significant bit first. The first bit selects the operation (1 = write, 0 = read). The next 22 bits are the word address. A write then carries 32 data bits.
- R2: A read request appears on `bus_req` no more than 6 system cycles after the rising serial edge that carries the last address bit. `bus_req` is a single-cycle pulse, and at most one access is outstanding until `bus_ack`.
- R3: In a read frame, the `pad_bytes` × 8 bit times that follow the address all return 1 on MISO.
- R4: The read word starts on MISO in the bit time right after the padding. It is sent most significant bit first and equals the `bus_rdata` value that came with the acknowledge.
- R5: A write request is issued once per frame, and only after the 32nd data bit has been received with chip select 0 still low. It carries the received address and data.
- R6: Raising chip select 0 before a frame completes produces no write access. The next frame is decoded from its first bit.
- R7: Frames on any chip select line other than bit 0 of `spi_cs_n` produce no bus access and leave `spi_miso_oe` low.
- R8: If no read data is available when its first bit must be driven, the 32 data bits are all ones and `late_err` is set. `late_err` then stays set until reset.
- R9: `spi_miso_oe` is high while chip select 0 is low. MISO is 1 whenever the bridge is not shifting read data.
- R10: After reset, `bus_req` and `late_err` are 0, `spi_miso` is 1 and `spi_miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | NCS | Active-low chip select lines; only bit 0 selects this bridge |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad |
| pad_bytes | input | PAD_W | Number of padding bytes sent before read data |
| bus_req | output | 1 | One-cycle register access request |
| bus_we | output | 1 | Access is a write when high |
| bus_addr | output | ADDR_W | Register word address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | One-cycle completion from the register target |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| late_err | output | 1 | Sticky flag: read data was not ready in time |

## Verification
The hardest case to reach is a read whose acknowledge arrives after the bridge has already committed to its first data bit. That response lands in the middle of the data phase and must be discarded. The bench reaches this case with a register target model whose latency is set per frame. It runs a zero-padding read against a 20-cycle latency, which is longer than half a serial period, and then a padded read against the same register. This shows the flag stays set while good data still comes back. Frames cut short in the address and in the data field are followed by full frames, which shows that the bit counter restarts.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

   typedef enum logic {
      SPI_OP_READ  = 1'b0,
      SPI_OP_WRITE = 1'b1
   } spi_op_e;

   // Largest padding field value, expressed in serial bit times.
   function automatic int pad_bits_max(input int pad_w);
      return ((1 << pad_w) - 1) * 8;
   endfunction

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 0) begin : g_chk_stages
      $error("spi_rb_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
         end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
               stg[s] <= stg[s-1];
            end
         end
      end

      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/spi_rb_rx.sv
module spi_rb_rx #(
   parameter int SH_W    = 32,
   parameter int CNT_W   = 7,
   parameter int CNT_MAX = 79
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_on,
   input  logic             rise,
   input  logic             sdi,
   output logic [CNT_W-1:0] cnt,
   output logic [SH_W-1:0]  shreg,
   output logic             rise_q
);

   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

   if (SH_W < 2) begin : g_chk_sh
      $error("spi_rb_rx: SH_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         shreg  <= '0;
         rise_q <= 1'b0;
      end else begin
         rise_q <= rise & frame_on;
         if (!frame_on) begin
            cnt <= '0;
         end else if (rise) begin
            shreg <= {shreg[SH_W-2:0], sdi};
            if (cnt != CNT_TOP) begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/spi_rb_tx.sv
module spi_rb_tx #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_on,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              shift,
   output logic              sdo,
   output logic              in_data
);

   logic [DATA_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr      <= '1;
         in_data <= 1'b0;
      end else if (!frame_on) begin
         sr      <= '1;
         in_data <= 1'b0;
      end else if (load) begin
         sr      <= load_val;
         in_data <= 1'b1;
      end else if (shift && in_data) begin
         sr <= {sr[DATA_W-2:0], 1'b1};
      end
   end

   assign sdo = in_data ? sr[DATA_W-1] : 1'b1;

endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
   import spi_rb_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int DATA_W      = 32,
   parameter int NCS         = 4,
   parameter int PAD_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic [NCS-1:0]    spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   input  logic [PAD_W-1:0]  pad_bytes,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              late_err
);

   localparam int HDR_BITS = 1 + ADDR_W;
   localparam int SH_W     = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
   localparam int CNT_MAX  = HDR_BITS + pad_bits_max(PAD_W) + DATA_W;
   localparam int CNT_W    = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] HDR_END = CNT_W'(HDR_BITS);
   localparam logic [CNT_W-1:0] WR_END  = CNT_W'(HDR_BITS + DATA_W);

   // ---------------- elaboration checks ----------------
   if (ADDR_W < 1) begin : g_chk_addr
      $error("spi_reg_bridge: ADDR_W must be positive");
   end
   if (DATA_W < 8) begin : g_chk_data
      $error("spi_reg_bridge: DATA_W must be at least 8");
   end
   if (PAD_W < 1 || PAD_W > 4) begin : g_chk_pad
      $error("spi_reg_bridge: PAD_W must lie in 1..4");
   end
   if (NCS < 1) begin : g_chk_ncs
      $error("spi_reg_bridge: NCS must be positive");
   end

   // Only line 0 selects this bridge; the others are deliberately unused.
   if (NCS > 1) begin : g_spare_cs
      logic unused_cs;
      assign unused_cs = ^spi_cs_n[NCS-1:1];
   end

   // ---------------- pin synchronization and edge detect ----------------
   logic [2:0] pins_s;
   logic       cs_s, sck_s, mosi_s, sck_d;
   logic       frame_on, sck_rise, sck_fall;

   spi_rb_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n[0], spi_sck, spi_mosi}),
      .q     (pins_s)
   );

   assign {cs_s, sck_s, mosi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign frame_on = ~cs_s;
   assign sck_rise = frame_on &  sck_s & ~sck_d;
   assign sck_fall = frame_on & ~sck_s &  sck_d;

   // ---------------- receive path ----------------
   logic [CNT_W-1:0] rx_cnt;
   logic [SH_W-1:0]  rx_sh;
   logic             rx_rise_q;

   spi_rb_rx #(
      .SH_W    (SH_W),
      .CNT_W   (CNT_W),
      .CNT_MAX (CNT_MAX)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_on (frame_on),
      .rise     (sck_rise),
      .sdi      (mosi_s),
      .cnt      (rx_cnt),
      .shreg    (rx_sh),
      .rise_q   (rx_rise_q)
   );

   // ---------------- frame decode and bus master ----------------
   spi_op_e           rw_q;
   logic [ADDR_W-1:0] addr_q;
   logic [PAD_W-1:0]  pad_q;
   logic              outstanding, busy;
   logic              hdr_hit, wr_hit, issue_rd, issue_wr;
   logic              rd_wait, rd_ready, rd_avail;
   logic [DATA_W-1:0] rd_hold;
   logic              tx_load, tx_in_data;
   logic [DATA_W-1:0] tx_val;
   logic [CNT_W-1:0]  data_start;

   assign busy     = outstanding | bus_req;
   assign hdr_hit  = rx_rise_q && (rx_cnt == HDR_END);
   assign wr_hit   = rx_rise_q && (rx_cnt == WR_END) && (rw_q == SPI_OP_WRITE);
   assign issue_rd = hdr_hit && (spi_op_e'(rx_sh[HDR_BITS-1]) == SPI_OP_READ) && !busy;
   assign issue_wr = wr_hit && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_req     <= 1'b0;
         bus_we      <= 1'b0;
         bus_addr    <= '0;
         bus_wdata   <= '0;
         outstanding <= 1'b0;
         rw_q        <= SPI_OP_READ;
         addr_q      <= '0;
         pad_q       <= '0;
      end else begin
         bus_req <= issue_rd | issue_wr;
         if (issue_rd) begin
            bus_we   <= 1'b0;
            bus_addr <= rx_sh[ADDR_W-1:0];
         end else if (issue_wr) begin
            bus_we    <= 1'b1;
            bus_addr  <= addr_q;
            bus_wdata <= rx_sh[DATA_W-1:0];
         end
         if (bus_ack)      outstanding <= 1'b0;
         else if (bus_req) outstanding <= 1'b1;
         if (hdr_hit) begin
            rw_q   <= spi_op_e'(rx_sh[HDR_BITS-1]);
            addr_q <= rx_sh[ADDR_W-1:0];
            pad_q  <= pad_bytes;
         end
      end
   end

   // ---------------- read data capture and late detection ----------------
   assign rd_avail   = rd_ready | (rd_wait & bus_ack);
   assign data_start = HDR_END + CNT_W'({pad_q, 3'b000});
   assign tx_load    = sck_fall && (rw_q == SPI_OP_READ) && (rx_cnt == data_start) && !tx_in_data;
   assign tx_val     = rd_ready ? rd_hold : (rd_avail ? bus_rdata : '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_wait  <= 1'b0;
         rd_ready <= 1'b0;
         rd_hold  <= '0;
         late_err <= 1'b0;
      end else begin
         if (!frame_on) begin
            rd_wait  <= 1'b0;
            rd_ready <= 1'b0;
         end else begin
            if (issue_rd) rd_wait <= 1'b1;
            if (rd_wait && bus_ack && !rd_ready) begin
               rd_ready <= 1'b1;
               rd_hold  <= bus_rdata;
            end
         end
         if (tx_load && !rd_avail) late_err <= 1'b1;
      end
   end

   // ---------------- transmit path ----------------
   spi_rb_tx #(
      .DATA_W (DATA_W)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_on (frame_on),
      .load     (tx_load),
      .load_val (tx_val),
      .shift    (sck_fall),
      .sdo      (spi_miso),
      .in_data  (tx_in_data)
   );

   assign spi_miso_oe = frame_on;

   // ---------------- assertions ----------------
   AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> !bus_req); // R2
   AST_ACK_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |-> outstanding); // R2
   AST_NO_REQ_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && $past(cs_s)) |=> !bus_req); // R7
   AST_WRITE_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |-> ($past(rx_cnt) == WR_END)); // R5
   AST_LOAD_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_in_data) |-> (rw_q == SPI_OP_READ)); // R4
   AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      late_err |=> late_err); // R8

endmodule

// File: tb/spi_reg_bridge_tb.sv
`timescale 1ns/1ps
module spi_reg_bridge_tb;

   localparam int AW  = 22;
   localparam int DW  = 32;
   localparam int NCS = 4;
   localparam int PW  = 2;
   localparam int H   = 8;   // system cycles per serial clock phase

   typedef struct packed {
      logic          we;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sck = 1'b0;
   logic           mosi = 1'b0;
   logic [NCS-1:0] cs_n = '1;
   logic [PW-1:0]  pad = '0;
   logic           miso, oe, req, we, late;
   logic [AW-1:0]  baddr;
   logic [DW-1:0]  wdata;
   logic           ack = 1'b0;
   logic [DW-1:0]  rdata = '0;

   int   vectors = 0;
   int   errs = 0;
   int   cyc = 0;
   int   hdr_cyc = 0;
   int   lat = 3;
   bit   done = 1'b0;
   exp_t exp_q[$];
   logic [DW-1:0] mem [64];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   spi_reg_bridge u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_sck     (sck),
      .spi_cs_n    (cs_n),
      .spi_mosi    (mosi),
      .spi_miso    (miso),
      .spi_miso_oe (oe),
      .pad_bytes   (pad),
      .bus_req     (req),
      .bus_we      (we),
      .bus_addr    (baddr),
      .bus_wdata   (wdata),
      .bus_ack     (ack),
      .bus_rdata   (rdata),
      .late_err    (late)
   );

   function automatic logic [DW-1:0] init_val(input int i);
      return 32'hC300_0000 ^ (32'(i) * 32'h0102_0304);
   endfunction

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
      vectors++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual %h expected %h", what, act, expv);
      end
   endtask

   // Register target model and scoreboard monitor
   initial begin
      exp_t          e;
      logic          m_we;
      logic [AW-1:0] m_addr;
      logic [DW-1:0] m_data;
      int            m_cyc;
      forever begin
         @(negedge clk);
         if (rst_n && req) begin
            m_we = we; m_addr = baddr; m_data = wdata; m_cyc = cyc;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5/R6/R7 unexpected bus request", {31'b0, m_we, 10'b0, m_addr}, 64'h0);
            end else begin
               e = exp_q.pop_front();
               chk(m_we == e.we, "R1 access direction", 64'(m_we), 64'(e.we));
               chk(m_addr == e.addr, "R1 access address", 64'(m_addr), 64'(e.addr));
               if (e.we) chk(m_data == e.data, "R5 write data", 64'(m_data), 64'(e.data));
               else chk((m_cyc - hdr_cyc) <= 6, "R2 read launch delay", 64'(m_cyc - hdr_cyc), 64'd6);
            end
            repeat (lat) @(negedge clk);
            ack = 1'b1;
            rdata = mem[m_addr[5:0]];
            if (m_we) mem[m_addr[5:0]] = m_data;
            @(negedge clk);
            ack = 1'b0;
         end
      end
   end

   // One SPI mode 0 master transfer; sends the first n of len bits, MSB first.
   task automatic spi_xfer(input int csi, input int len, input int n, input logic [127:0] mo,
                           output logic [127:0] mi, output logic oe_any);
      mi = '1;
      oe_any = 1'b0;
      @(negedge clk);
      cs_n[csi] = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         mosi = mo[len-1-i];
         repeat (H) @(negedge clk);
         sck = 1'b1;
         mi[len-1-i] = miso;
         oe_any = oe_any | oe;
         if (i == AW) hdr_cyc = cyc;
         repeat (H) @(negedge clk);
         sck = 1'b0;
      end
      repeat (H) @(negedge clk);
      cs_n[csi] = 1'b1;
      repeat (4*H) @(negedge clk);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit expect_access);
      logic [127:0] mi;
      logic         o;
      if (expect_access) exp_q.push_back('{we: 1'b1, addr: a, data: d});
      spi_xfer(0, 1+AW+DW, 1+AW+DW, 128'({1'b1, a, d}), mi, o);
      chk(exp_q.size() == 0, "R5 write access issued", 64'(exp_q.size()), 64'd0);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input int p, input int l,
                          output logic [DW-1:0] d, output logic [DW-1:0] padv, output logic o);
      logic [127:0] mi;
      int           len;
      pad = PW'(p);
      lat = l;
      len = 1 + AW + p*8 + DW;
      exp_q.push_back('{we: 1'b0, addr: a, data: '0});
      spi_xfer(0, len, len, 128'({1'b0, a}) << (p*8 + DW), mi, o);
      d = mi[DW-1:0];
      padv = DW'(mi >> DW);
      chk(exp_q.size() == 0, "R2 read access issued", 64'(exp_q.size()), 64'd0);
   endtask

   initial begin
      logic [DW-1:0] d, pv, mask;
      logic [127:0]  mi;
      logic          o;
      for (int i = 0; i < 64; i++) mem[i] = init_val(i);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R10 / R9: reset and idle state
      chk(req == 1'b0, "R10 bus_req after reset", 64'(req), 64'd0);
      chk(late == 1'b0, "R10 late_err after reset", 64'(late), 64'd0);
      chk(miso == 1'b1, "R10 miso idle", 64'(miso), 64'd1);
      chk(oe == 1'b0, "R9 miso_oe idle", 64'(oe), 64'd0);

      // R1 / R5: writes, including high address bits
      pad = 2'd1; lat = 3;
      do_write(22'h2A5A5, 32'hDEAD_BEEF, 1'b1);
      do_write(22'h3F0C21, 32'h0F1E_2D3C, 1'b1);

      // R3 / R4 / R9: read back with one padding byte
      do_read(22'h2A5A5, 1, 3, d, pv, o);
      chk(d == 32'hDEAD_BEEF, "R4 read data pad=1", 64'(d), 64'hDEADBEEF);
      chk(pv[7:0] == 8'hFF, "R3 padding ones pad=1", 64'(pv[7:0]), 64'hFF);
      chk(o == 1'b1, "R9 miso_oe during frame", 64'(o), 64'd1);
      do_read(22'h3F0C21, 1, 3, d, pv, o);
      chk(d == 32'h0F1E_2D3C, "R1 read data high address", 64'(d), 64'h0F1E2D3C);

      // R4: zero padding with a fast target
      do_read(22'h000005, 0, 2, d, pv, o);
      chk(d == init_val(5), "R4 read data pad=0", 64'(d), 64'(init_val(5)));
      chk(late == 1'b0, "R8 no late flag on timely read", 64'(late), 64'd0);

      // R3: three padding bytes hide a slow target
      do_read(22'h000007, 3, 150, d, pv, o);
      mask = 32'h00FF_FFFF;
      chk(d == init_val(7), "R3 read data pad=3 slow target", 64'(d), 64'(init_val(7)));
      chk((pv & mask) == mask, "R3 padding ones pad=3", 64'(pv & mask), 64'(mask));
      lat = 3;

      // R7: other chip select lines are ignored
      spi_xfer(1, 1+AW+DW, 1+AW+DW, 128'({1'b1, 22'h000009, 32'h1111_2222}), mi, o);
      chk(o == 1'b0, "R7 miso_oe stays low on other select", 64'(o), 64'd0);
      chk(mi[54:0] == {55{1'b1}}, "R7 miso stays high on other select", 64'(mi[54:0]), 64'h7FFFFFFFFFFFFF);
      do_read(22'h000009, 1, 3, d, pv, o);
      chk(d == init_val(9), "R7 register untouched by other select", 64'(d), 64'(init_val(9)));

      // R6: abort inside the data field, then inside the address field
      pad = 2'd1;
      spi_xfer(0, 1+AW+DW, 40, 128'({1'b1, 22'h00000B, 32'hAAAA_5555}), mi, o);
      do_read(22'h00000B, 1, 3, d, pv, o);
      chk(d == init_val(11), "R6 aborted write has no effect", 64'(d), 64'(init_val(11)));
      spi_xfer(0, 1+AW+DW, 10, 128'({1'b1, 22'h3FFFFF, 32'hFFFF_FFFF}), mi, o);
      do_write(22'h00000C, 32'h1234_5678, 1'b1);
      do_read(22'h00000C, 1, 3, d, pv, o);
      chk(d == 32'h1234_5678, "R6 frame after abort decodes from bit 0", 64'(d), 64'h12345678);

      // R8: late read, then sticky flag with good data
      do_read(22'h000005, 0, 20, d, pv, o);
      chk(d == 32'hFFFF_FFFF, "R8 late read returns all ones", 64'(d), 64'hFFFFFFFF);
      chk(late == 1'b1, "R8 late_err set", 64'(late), 64'd1);
      do_read(22'h000005, 1, 3, d, pv, o);
      chk(d == init_val(5), "R8 later read still correct", 64'(d), 64'(init_val(5)));
      chk(late == 1'b1, "R8 late_err sticky", 64'(late), 64'd1);

      repeat (50) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end

endmodule